// File: doc/BRIEF.md
# BAR Window Validation Unit

This unit decides, for every address window of a configuration header, whether that window is live on the bus and where it begins. Six base registers and one expansion-ROM register arrive as raw 32-bit words. The two decode-enable bits of the command register arrive as plain pins. For each region a static kind (absent, I/O, 32-bit memory, 64-bit memory) and a power-of-two size are supplied as configuration inputs. The unit aligns each base down to its size and applies the range rules. It keeps the resulting mapping as registered state that downstream address decoders can use directly.

A new evaluation runs only when one of the six base words or one of the two enable bits changes. When an evaluation produces a mapping different from the stored one, the unit first emits a one-cycle release event carrying the old base. One cycle later it emits a map event for the new base. If the mapping moves straight from unmapped to mapped, only the map event is emitted. The events are plain single-cycle pulses with no back-pressure, so a consumer must take each event in the cycle it appears. The stored configuration words themselves live outside this block.

Top module: `bar_window_unit`

## Requirements
- R1: Kind codes are 2'b00 absent, 2'b01 I/O, 2'b10 32-bit memory and 2'b11 64-bit memory. An I/O region can be mapped only while `cmd_io_en` is 1. A memory region can be mapped only while `cmd_mem_en` is 1. An absent region is never mapped.
- R2: With size 2^lg, the candidate base is the raw value with its lowest lg bits cleared. The window end is the base plus 2^lg - 1.
- R3: An I/O window is rejected if its end is not above its base, if its base is zero, or if its end is 0x10000 or higher.
- R4: A 32-bit memory window is rejected if its end is not above its base (which includes lg=0), if its base is zero, or if its end is 0xFFFFFFFF or higher.
- R5: The ROM region is region index NUM_BARS, fed from `rom_word_i`. Any non-zero kind makes it a 32-bit memory region. It is additionally rejected whenever bit 0 of its raw word is 0.
- R6: A 64-bit region at index i takes its low word from base word i and its high word from word i+1. A 64-bit kind on the last base word is always rejected.
- R7: A 64-bit window is rejected if its end wraps past 2^64, equals all ones, reaches 2^PHYS_W or more, or if its base is zero. An end of exactly 2^PHYS_W - 1 is accepted.
- R8: A re-evaluation is triggered only by a change in any byte of the six base words, or by a change in either enable bit. A change of `rom_word_i`, kind or size alone leaves every output unchanged until the next trigger.
- R9: An unmapped region shows `map_valid_o` = 0 with its 64-bit base all ones. During reset every region is unmapped and no event is raised.
- R10: When a mapped region changes, `rel_evt_o` pulses with `rel_base_o` holding the old base while `map_valid_o` drops. The `map_evt_o` pulse for the new window follows on the next cycle, never in the same cycle.
- R11: A trigger whose result equals the stored mapping raises no event and leaves the outputs unchanged.
- R12: A map event from the unmapped state appears at the second rising edge after the input change. A release event appears at the second rising edge, and the map event that follows it appears at the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_io_en | input | 1 | Command register I/O decode enable |
| cmd_mem_en | input | 1 | Command register memory decode enable |
| bar_word_i | input | NUM_BARS*32 | Raw base words, word i at bits [32i+31:32i] |
| rom_word_i | input | 32 | Raw expansion-ROM word, bit 0 is its enable |
| region_kind_i | input | NREG*2 | Per-region kind code, region r at [2r+1:2r] |
| region_lg_i | input | NREG*6 | Per-region log2 of window size |
| map_valid_o | output | NREG | Region currently mapped |
| map_base_o | output | NREG*64 | Current base per region, all ones when unmapped |
| rel_evt_o | output | NREG | One-cycle release pulse per region |
| rel_base_o | output | NREG*64 | Base of the most recently released window |
| map_evt_o | output | NREG | One-cycle map pulse per region |

## Verification
The bench builds the unit with NUM_BARS = 6 and PHYS_W = 36. The narrow physical width lets 64-bit windows land on both sides of the address limit using only small high words, including an end of exactly 2^36 - 1. Keeping six base words puts the ROM at index 6 and makes word 5 the unpaired last slot. That makes both the ROM trigger rule and the last-slot 64-bit rejection reachable.

// File: rtl/bwv_pkg.sv
package bwv_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned LG_W   = 6;
  localparam int unsigned KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    RK_NONE  = 2'b00,
    RK_IO    = 2'b01,
    RK_MEM32 = 2'b10,
    RK_MEM64 = 2'b11
  } region_kind_e;

  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] base;
  } window_t;

  localparam logic [ADDR_W-1:0] UNMAPPED_BASE = '1;
  localparam logic [ADDR_W-1:0] IO_LIMIT      = 64'h0000_0000_0001_0000;
  localparam logic [ADDR_W-1:0] MEM32_LIMIT   = 64'h0000_0000_FFFF_FFFF;
endpackage

// File: rtl/bwv_snapshot.sv
module bwv_snapshot
  import bwv_pkg::*;
#(
  parameter int unsigned NUM_BARS = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_io_en,
  input  logic                       cmd_mem_en,
  input  logic [NUM_BARS*WORD_W-1:0] bar_word_i,
  input  logic [WORD_W-1:0]          rom_word_i,
  output logic [NUM_BARS*WORD_W-1:0] bar_q,
  output logic [WORD_W-1:0]          rom_q,
  output logic                       io_q,
  output logic                       mem_q,
  output logic                       eval_o
);
  localparam int unsigned NBYTES = NUM_BARS * WORD_W / 8;

  logic [NBYTES-1:0] byte_diff;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign byte_diff[b] = (bar_word_i[b*8 +: 8] != bar_q[b*8 +: 8]);
  end

  // The ROM word is captured every cycle but never starts an evaluation.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar_q  <= '0;
      rom_q  <= '0;
      io_q   <= 1'b0;
      mem_q  <= 1'b0;
      eval_o <= 1'b0;
    end else begin
      bar_q  <= bar_word_i;
      rom_q  <= rom_word_i;
      io_q   <= cmd_io_en;
      mem_q  <= cmd_mem_en;
      eval_o <= (|byte_diff) || (cmd_io_en != io_q) || (cmd_mem_en != mem_q);
    end
  end
endmodule

// File: rtl/bwv_decode.sv
module bwv_decode
  import bwv_pkg::*;
#(
  parameter int unsigned PHYS_W   = 40,
  parameter bit          IS_ROM   = 1'b0,
  parameter bit          HAS_PAIR = 1'b1
) (
  input  logic [KIND_W-1:0] kind_i,
  input  logic [LG_W-1:0]   lg_i,
  input  logic              io_en_i,
  input  logic              mem_en_i,
  input  logic [WORD_W-1:0] lo_i,
  input  logic [WORD_W-1:0] hi_i,
  output window_t           win_o
);
  localparam logic [ADDR_W-1:0] PHYS_MAX = (64'd1 << PHYS_W) - 64'd1;

  region_kind_e      kind_eff;
  logic [ADDR_W-1:0] size_m1;
  logic [ADDR_W-1:0] raw;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W:0]   end_ext;
  logic [ADDR_W-1:0] last;
  logic              wraps;
  logic              ok;

  always_comb begin
    if (IS_ROM) kind_eff = (kind_i != RK_NONE) ? RK_MEM32 : RK_NONE;
    else        kind_eff = region_kind_e'(kind_i);

    size_m1 = (64'd1 << lg_i) - 64'd1;
    if (kind_eff == RK_MEM64) raw = {hi_i, lo_i};
    else                      raw = {32'b0, lo_i};
    base    = raw & ~size_m1;
    end_ext = {1'b0, base} + {1'b0, size_m1};
    last    = end_ext[ADDR_W-1:0];
    wraps   = end_ext[ADDR_W] || (last <= base);

    unique case (kind_eff)
      RK_IO:    ok = io_en_i && !wraps && (base != '0) && (last < IO_LIMIT);
      RK_MEM32: ok = mem_en_i && !wraps && (base != '0) && (last < MEM32_LIMIT)
                     && (!IS_ROM || lo_i[0]);
      RK_MEM64: ok = HAS_PAIR && mem_en_i && !wraps && (base != '0)
                     && (last != UNMAPPED_BASE) && (last <= PHYS_MAX);
      default:  ok = 1'b0;
    endcase

    win_o.valid = ok;
    win_o.base  = ok ? base : UNMAPPED_BASE;
  end
endmodule

// File: rtl/bwv_tracker.sv
module bwv_tracker
  import bwv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_i,
  input  window_t           cand_i,
  output window_t           cur_o,
  output logic              rel_evt_o,
  output logic [ADDR_W-1:0] rel_base_o,
  output logic              map_evt_o
);
  typedef enum logic {TR_IDLE, TR_REMAP} tr_state_e;

  tr_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= TR_IDLE;
      cur_o      <= '{valid: 1'b0, base: UNMAPPED_BASE};
      rel_evt_o  <= 1'b0;
      rel_base_o <= UNMAPPED_BASE;
      map_evt_o  <= 1'b0;
    end else begin
      rel_evt_o <= 1'b0;
      map_evt_o <= 1'b0;
      unique case (state)
        TR_IDLE: begin
          if (eval_i && (cand_i != cur_o)) begin
            if (cur_o.valid) begin
              rel_evt_o  <= 1'b1;
              rel_base_o <= cur_o.base;
              cur_o      <= '{valid: 1'b0, base: UNMAPPED_BASE};
              if (cand_i.valid) state <= TR_REMAP;
            end else begin
              cur_o     <= cand_i;
              map_evt_o <= 1'b1;
            end
          end
        end
        TR_REMAP: begin
          state <= TR_IDLE;
          if (cand_i.valid) begin
            cur_o     <= cand_i;
            map_evt_o <= 1'b1;
          end
        end
        default: state <= TR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bar_window_unit.sv
module bar_window_unit
  import bwv_pkg::*;
#(
  parameter int unsigned NUM_BARS = 6,
  parameter int unsigned PHYS_W   = 40,
  localparam int unsigned NREG    = NUM_BARS + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_io_en,
  input  logic                       cmd_mem_en,
  input  logic [NUM_BARS*WORD_W-1:0] bar_word_i,
  input  logic [WORD_W-1:0]          rom_word_i,
  input  logic [NREG*KIND_W-1:0]     region_kind_i,
  input  logic [NREG*LG_W-1:0]       region_lg_i,
  output logic [NREG-1:0]            map_valid_o,
  output logic [NREG*ADDR_W-1:0]     map_base_o,
  output logic [NREG-1:0]            rel_evt_o,
  output logic [NREG*ADDR_W-1:0]     rel_base_o,
  output logic [NREG-1:0]            map_evt_o
);
  logic [NUM_BARS*WORD_W-1:0] bar_q;
  logic [WORD_W-1:0]          rom_q;
  logic                       io_q;
  logic                       mem_q;
  logic                       eval;

  bwv_snapshot #(.NUM_BARS(NUM_BARS)) u_snap (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_io_en  (cmd_io_en),
    .cmd_mem_en (cmd_mem_en),
    .bar_word_i (bar_word_i),
    .rom_word_i (rom_word_i),
    .bar_q      (bar_q),
    .rom_q      (rom_q),
    .io_q       (io_q),
    .mem_q      (mem_q),
    .eval_o     (eval)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_region
    logic [WORD_W-1:0] lo_w;
    logic [WORD_W-1:0] hi_w;
    window_t           cand;
    window_t           cur;

    if (r < NUM_BARS) begin : g_lo_bar
      assign lo_w = bar_q[r*WORD_W +: WORD_W];
    end else begin : g_lo_rom
      assign lo_w = rom_q;
    end

    if (r + 1 < NUM_BARS) begin : g_hi_pair
      assign hi_w = bar_q[(r+1)*WORD_W +: WORD_W];
    end else begin : g_hi_none
      assign hi_w = '0;
    end

    bwv_decode #(
      .PHYS_W   (PHYS_W),
      .IS_ROM   (r == NUM_BARS),
      .HAS_PAIR (r + 1 < NUM_BARS)
    ) u_dec (
      .kind_i   (region_kind_i[r*KIND_W +: KIND_W]),
      .lg_i     (region_lg_i[r*LG_W +: LG_W]),
      .io_en_i  (io_q),
      .mem_en_i (mem_q),
      .lo_i     (lo_w),
      .hi_i     (hi_w),
      .win_o    (cand)
    );

    bwv_tracker u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .eval_i     (eval),
      .cand_i     (cand),
      .cur_o      (cur),
      .rel_evt_o  (rel_evt_o[r]),
      .rel_base_o (rel_base_o[r*ADDR_W +: ADDR_W]),
      .map_evt_o  (map_evt_o[r])
    );

    assign map_valid_o[r]                = cur.valid;
    assign map_base_o[r*ADDR_W +: ADDR_W] = cur.base;
  end
endmodule

// File: rtl/bar_window_chk.sv
module bar_window_chk #(
  parameter int unsigned NREG   = 7,
  parameter int unsigned ADDR_W = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NREG-1:0]        map_valid_o,
  input logic [NREG*ADDR_W-1:0] map_base_o,
  input logic [NREG-1:0]        rel_evt_o,
  input logic [NREG-1:0]        map_evt_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_chk
    AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      !map_valid_o[r] |-> (map_base_o[r*ADDR_W +: ADDR_W] == {ADDR_W{1'b1}})); // R9
    AST_MAPPED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      map_valid_o[r] |-> (map_base_o[r*ADDR_W +: ADDR_W] != '0)); // R3
    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rel_evt_o[r] && map_evt_o[r])); // R10
    AST_REL_FROM_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      rel_evt_o[r] |-> ($past(map_valid_o[r]) && !map_valid_o[r])); // R10
    AST_MAP_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      map_evt_o[r] |-> map_valid_o[r]); // R10
    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rel_evt_o[r] && !map_evt_o[r]) |->
        ($stable(map_valid_o[r]) && $stable(map_base_o[r*ADDR_W +: ADDR_W]))); // R11
  end
endmodule

bind bar_window_unit bar_window_chk #(.NREG(NREG), .ADDR_W(bwv_pkg::ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .map_valid_o (map_valid_o),
  .map_base_o  (map_base_o),
  .rel_evt_o   (rel_evt_o),
  .map_evt_o   (map_evt_o)
);

// File: tb/tb_bar_window_unit.sv
module tb_bar_window_unit;
  localparam int unsigned NB   = 6;
  localparam int unsigned PW   = 36;
  localparam int unsigned NR   = NB + 1;
  localparam logic [63:0] ONES = '1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              io_en = 1'b0;
  logic              mem_en = 1'b0;
  logic [NB*32-1:0]  bars = '0;
  logic [31:0]       rom = '0;
  logic [NR*2-1:0]   kinds = '0;
  logic [NR*6-1:0]   lgs = '0;
  logic [NR-1:0]     mvalid;
  logic [NR*64-1:0]  mbase;
  logic [NR-1:0]     revt;
  logic [NR*64-1:0]  rbase;
  logic [NR-1:0]     mevt;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bar_window_unit #(.NUM_BARS(NB), .PHYS_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_io_en(io_en), .cmd_mem_en(mem_en),
    .bar_word_i(bars), .rom_word_i(rom), .region_kind_i(kinds),
    .region_lg_i(lgs), .map_valid_o(mvalid), .map_base_o(mbase),
    .rel_evt_o(revt), .rel_base_o(rbase), .map_evt_o(mevt)
  );

  typedef struct packed {
    logic [7:0]  rq;
    logic [1:0]  kind;
    logic [5:0]  lg;
    logic        io;
    logic        mem;
    logic [31:0] lo;
    logic [31:0] hi;
    logic        ev;
    logic [63:0] eb;
  } vec_t;

  localparam vec_t VECS [15] = '{
    '{8'd2, 2'b01, 6'd3,  1'b1, 1'b0, 32'h0000_C001, 32'h0, 1'b1, 64'h0000_C000},       // R2 I/O align
    '{8'd1, 2'b01, 6'd3,  1'b0, 1'b1, 32'h0000_C001, 32'h0, 1'b0, ONES},                // R1 I/O needs io enable
    '{8'd3, 2'b01, 6'd3,  1'b1, 1'b0, 32'h0000_0001, 32'h0, 1'b0, ONES},                // R3 base zero
    '{8'd3, 2'b01, 6'd3,  1'b1, 1'b0, 32'h0000_FFF9, 32'h0, 1'b1, 64'h0000_FFF8},       // R3 end 0xFFFF ok
    '{8'd3, 2'b01, 6'd3,  1'b1, 1'b0, 32'h0001_0001, 32'h0, 1'b0, ONES},                // R3 beyond 64K
    '{8'd2, 2'b10, 6'd12, 1'b0, 1'b1, 32'hFEBF_1008, 32'h0, 1'b1, 64'hFEBF_1000},       // R2 mem align
    '{8'd1, 2'b10, 6'd12, 1'b1, 1'b0, 32'hFEBF_1008, 32'h0, 1'b0, ONES},                // R1 mem needs mem enable
    '{8'd4, 2'b10, 6'd12, 1'b0, 1'b1, 32'hFFFF_F000, 32'h0, 1'b0, ONES},                // R4 end all ones
    '{8'd4, 2'b10, 6'd12, 1'b0, 1'b1, 32'hFFFF_E000, 32'h0, 1'b1, 64'hFFFF_E000},       // R4 just below
    '{8'd6, 2'b11, 6'd20, 1'b0, 1'b1, 32'h0010_000C, 32'h8, 1'b1, 64'h8_0010_0000},     // R6 pair
    '{8'd7, 2'b11, 6'd20, 1'b0, 1'b1, 32'h0010_000C, 32'h10, 1'b0, ONES},               // R7 above phys
    '{8'd7, 2'b11, 6'd20, 1'b0, 1'b1, 32'hFFF0_000C, 32'hF, 1'b1, 64'hF_FFF0_0000},     // R7 end = limit
    '{8'd1, 2'b01, 6'd3,  1'b0, 1'b1, 32'h0000_C001, 32'h0, 1'b0, ONES},                // R1 wrong enable
    '{8'd4, 2'b10, 6'd0,  1'b0, 1'b1, 32'h0000_1000, 32'h0, 1'b0, ONES},                // R4 size one wraps
    '{8'd6, 2'b11, 6'd20, 1'b0, 1'b1, 32'h0010_000C, 32'h0, 1'b1, 64'h0010_0000}        // R6 zero high
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; io_en = 1'b0; mem_en = 1'b0; bars = '0; rom = '0;
    nclk(2);
    rst_n = 1'b1;
    nclk(1);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state (R9)
    nclk(2);
    check("R9 valid in reset", 64'(mvalid), 64'd0);
    check("R9 base in reset r0", mbase[63:0], ONES);
    check("R9 base in reset rom", mbase[6*64 +: 64], ONES);
    check("R9 events in reset", 64'({revt, mevt}), 64'd0);

    // table walk on region 0
    for (int v = 0; v < 15; v++) begin
      kinds = '0; lgs = '0;
      kinds[1:0] = VECS[v].kind;
      lgs[5:0]   = VECS[v].lg;
      do_reset();
      io_en = VECS[v].io; mem_en = VECS[v].mem;
      bars[31:0] = VECS[v].lo; bars[63:32] = VECS[v].hi;
      nclk(4);
      check($sformatf("R%0d vec%0d valid", VECS[v].rq, v), 64'(mvalid[0]), 64'(VECS[v].ev));
      check($sformatf("R%0d vec%0d base", VECS[v].rq, v), mbase[63:0], VECS[v].eb);
    end

    // latency and release-then-map ordering (R12, R10)
    kinds = '0; lgs = '0; kinds[1:0] = 2'b10; lgs[5:0] = 6'd12;
    do_reset();
    mem_en = 1'b1; bars[31:0] = 32'h4000_0000;
    nclk(1);
    check("R12 no map after one edge", 64'(mevt[0]), 64'd0);
    nclk(1);
    check("R12 map at second edge", 64'(mevt[0]), 64'd1);
    check("R12 base", mbase[63:0], 64'h4000_0000);
    nclk(1);
    check("R12 map pulse one cycle", 64'(mevt[0]), 64'd0);
    bars[31:0] = 32'h5000_0000;
    nclk(2);
    check("R10 release pulse", 64'(revt[0]), 64'd1);
    check("R10 release carries old base", rbase[63:0], 64'h4000_0000);
    check("R10 unmapped during release", 64'(mvalid[0]), 64'd0);
    check("R10 no map with release", 64'(mevt[0]), 64'd0);
    nclk(1);
    check("R10 map follows", 64'(mevt[0]), 64'd1);
    check("R10 new base", mbase[63:0], 64'h5000_0000);

    // unchanged decode raises nothing (R11)
    begin
      int seen = 0;
      bars[31:0] = 32'h5000_0008;
      for (int i = 0; i < 4; i++) begin
        nclk(1);
        seen += int'(revt[0]) + int'(mevt[0]);
      end
      check("R11 no events", 64'(seen), 64'd0);
      check("R11 base kept", mbase[63:0], 64'h5000_0000);
    end

    // size change alone ignored, then applied on next trigger (R8)
    begin
      int seen = 0;
      lgs[5:0] = 6'd29;
      for (int i = 0; i < 4; i++) begin
        nclk(1);
        seen += int'(revt[0]) + int'(mevt[0]);
      end
      check("R8 size change no event", 64'(seen), 64'd0);
      check("R8 size change base kept", mbase[63:0], 64'h5000_0000);
      bars[3*32 +: 32] = 32'h0000_0100;
      nclk(4);
      check("R8 unrelated word triggers", mbase[63:0], 64'h4000_0000);
    end

    // ROM enable and ROM-only writes (R5, R8)
    kinds = '0; lgs = '0; kinds[13:12] = 2'b10; lgs[41:36] = 6'd16;
    do_reset();
    mem_en = 1'b1; rom = 32'h000C_0000;
    nclk(4);
    check("R5 rom disabled", 64'(mvalid[6]), 64'd0);
    rom = 32'h000C_0001;
    nclk(4);
    check("R8 rom write alone no trigger", 64'(mvalid[6]), 64'd0);
    bars[2*32 +: 32] = 32'h0000_0004;
    nclk(4);
    check("R5 rom mapped", 64'(mvalid[6]), 64'd1);
    check("R5 rom base", mbase[6*64 +: 64], 64'h000C_0000);

    // 64-bit kind on last base word (R6)
    kinds = '0; lgs = '0; kinds[11:10] = 2'b11; lgs[35:30] = 6'd20;
    do_reset();
    mem_en = 1'b1; bars[5*32 +: 32] = 32'h0010_000C;
    nclk(4);
    check("R6 last slot pair rejected", 64'(mvalid[5]), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule